// File: doc/BRIEF.md
# DDR Burst-of-Two SRAM Core

This block is a synthesizable model of a pipelined synchronous SRAM whose data port moves two 18-bit words per access, one on each half of the main clock period. Both halves of the main clock are represented by a single system clock that runs at twice the main rate. An internal phase flag separates main-clock rises (phase 0 before the edge) from complementary rises (phase 1 before the edge). The flag is brought out so that a controller can align to it. Commands are taken only at main-clock rises: a low load strobe with the read/write select high starts a read, and with it low starts a write.

Each access touches two words. The first is at the supplied address. The second is at the same address with its least significant bit advanced by a one-bit linear counter, so it wraps inside the pair. Write data arrive one word per fast edge, starting at the main rise that follows the command. Each word has its own active-low byte selects. Read data appear after one main cycle, or after one and a half, as a static mode input selects. A valid strobe marks each beat, and an output-enable models the bus going high-impedance once a read burst has drained.

A write issued at the main rise right after a read breaks the required idle cycle. The block flags this with a one-fast-cycle error pulse and still performs the write.

Top module: `ddr_burst_sram`

## Requirements
- R1: When `ld_n`=0 and `rw`=1 at a main-clock rise, a read of two words starts. Each word appears on `rdata` with `rdata_vld`=1 for exactly one fast cycle.
- R2: When `ld_n`=0 and `rw`=0 at a main-clock rise, a write starts. Word 0 is taken from `wdata` at the next main rise, and word 1 at the complementary rise after that.
- R3: Word 0 of a burst uses address A. Word 1 uses A with bit 0 inverted, and the upper bits stay unchanged (a one-bit linear counter that wraps).
- R4: With `lat_mode`=0, read word 0 is valid after the second fast edge following the command edge. With `lat_mode`=1, it is valid one fast edge later. Word 1 always follows word 0 on the next fast edge.
- R5: `bw_n` is active low and is sampled with each write word. `bw_n[0]` guards bits 8:0 and `bw_n[1]` guards bits 17:9. A byte whose select is 1 keeps its stored value.
- R6: A new command may be given at every main-clock rise. Every started access completes in full.
- R7: `rdata_oe` rises with the first read beat. It stays high until the first main-clock rise at which no beat is driven, and falls at that rise. `rdata` holds its value whenever `rdata_vld` is 0.
- R8: `proto_err` pulses high for one fast cycle when a write command is taken at the main rise directly after a read command. The write is still performed.
- R9: `ld_n`, `rw` and `addr` are ignored at complementary rises (phase 1). No access starts there.
- R10: After reset, `rdata`=0, `rdata_vld`=0, `rdata_oe`=0, `proto_err`=0 and `k_phase`=0. `k_phase` then toggles on every fast edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock at twice the main-clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| lat_mode | input | 1 | Static read latency select: 0 gives one cycle, 1 gives one and a half |
| ld_n | input | 1 | Active-low load strobe, sampled at main rises |
| rw | input | 1 | 1 selects read, 0 selects write |
| addr | input | AW | Burst start address |
| wdata | input | 18 | Write word of the current beat |
| bw_n | input | 2 | Active-low byte selects of the current beat |
| rdata | output | 18 | Read data |
| rdata_oe | output | 1 | Read bus drive enable (0 means high-impedance) |
| rdata_vld | output | 1 | Read beat strobe |
| proto_err | output | 1 | Write taken right after a read with no idle cycle |
| k_phase | output | 1 | Phase flag; 0 means the next edge is a main-clock rise |

## Verification
Internal state here is made up of two short beat-delay lines, a phase flag and the array. A slip in a delay line shows at the ports one fast edge early or late: the valid strobe lands off its slot, or a word lands on the wrong half cycle, and this is visible on the very next read burst. A wrong burst counter or a wrong byte merge corrupts stored words silently. That only surfaces when the same location is read back, so the bench reads every scenario's addresses again. A phase flag that is out of step moves every command decode and the output-enable fall by one fast cycle, and this shows at once on `k_phase` and `rdata_oe`.

// File: rtl/ddrb_pkg.sv
package ddrb_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Command decode: commands are only taken at main-clock rises.
  function automatic op_e decode_op(input logic ld_n, input logic rw, input logic main_edge);
    if (!main_edge || ld_n) return OP_IDLE;
    return rw ? OP_READ : OP_WRITE;
  endfunction

  // One-bit linear burst counter: start LSB advanced by the beat index.
  function automatic logic burst_lsb(input logic start, input logic beat);
    return start ^ beat;
  endfunction

endpackage

// File: rtl/ddrb_beat_line.sv
module ddrb_beat_line #(
  parameter int AW    = 6,
  parameter int SLOTS = 4,
  localparam int OFF_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins,
  input  logic [OFF_W-1:0] ins_off,
  input  logic [AW-1:0]    base,
  output logic             due,
  output logic [AW-1:0]    due_addr
);
  import ddrb_pkg::*;

  logic [SLOTS-1:0] vld_w;
  logic [AW-1:0]    adr_w [SLOTS];
  logic [AW-1:0]    beat0_addr, beat1_addr;

  assign beat0_addr = {base[AW-1:1], burst_lsb(base[0], 1'b0)};
  assign beat1_addr = {base[AW-1:1], burst_lsb(base[0], 1'b1)};

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic          shift_v;
    logic [AW-1:0] shift_a;
    logic          hit0, hit1;
    logic          v_q;
    logic [AW-1:0] a_q;

    if (i == SLOTS - 1) begin : g_tail
      assign shift_v = 1'b0;
      assign shift_a = '0;
    end else begin : g_body
      assign shift_v = vld_w[i+1];
      assign shift_a = adr_w[i+1];
    end

    assign hit0 = ins && (int'(ins_off) == i);
    assign hit1 = ins && (int'(ins_off) + 1 == i);

    always_ff @(posedge clk) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= hit0 | hit1 | shift_v;
    end

    always_ff @(posedge clk) begin
      if (hit0)      a_q <= beat0_addr;
      else if (hit1) a_q <= beat1_addr;
      else           a_q <= shift_a;
    end

    assign vld_w[i] = v_q;
    assign adr_w[i] = a_q;

    // R6: a newly scheduled beat never lands on a slot still carrying an older beat
    a_r6_no_slot_clash: assert property (@(posedge clk) disable iff (!rst_n)
      (hit0 || hit1) |-> !shift_v);
  end

  assign due      = vld_w[0];
  assign due_addr = adr_w[0];

endmodule

// File: rtl/ddrb_array.sv
module ddrb_array #(
  parameter int AW     = 6,
  parameter int BYTE_W = 9,
  parameter int NBYTE  = 2,
  localparam int WORD_W = BYTE_W * NBYTE,
  localparam int DEPTH  = 1 << AW
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [NBYTE-1:0]  wsel_n,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem [DEPTH];

  // Byte merge: an inactive (high) select keeps the stored byte.
  function automatic logic [WORD_W-1:0] merge_bytes(input logic [WORD_W-1:0] old_w,
                                                    input logic [WORD_W-1:0] new_w,
                                                    input logic [NBYTE-1:0]  sel_n);
    logic [WORD_W-1:0] r;
    for (int b = 0; b < NBYTE; b++)
      r[b*BYTE_W +: BYTE_W] = sel_n[b] ? old_w[b*BYTE_W +: BYTE_W] : new_w[b*BYTE_W +: BYTE_W];
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= merge_bytes(mem[waddr], wdata, wsel_n);
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/ddrb_out_stage.sv
module ddrb_out_stage #(
  parameter int WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic              main_edge,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] q,
  output logic              vld,
  output logic              oe
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q   <= '0;
      vld <= 1'b0;
      oe  <= 1'b0;
    end else begin
      vld <= beat;
      if (beat) begin
        q  <= din;
        oe <= 1'b1;
      end else if (main_edge) begin
        oe <= 1'b0;
      end
    end
  end

  // R7: a valid beat is always driven onto the bus
  a_r7_vld_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> oe);

  // R7: the bus is released only at a main-clock rise
  a_r7_oe_falls_on_main: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe) |-> $past(main_edge));

  // R7: data is held between beats
  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |-> $stable(q));

endmodule

// File: rtl/ddr_burst_sram.sv
module ddr_burst_sram #(
  parameter int AW     = 6,
  parameter int BYTE_W = 9,
  parameter int NBYTE  = 2,
  parameter int SLOTS  = 4,
  localparam int WORD_W = BYTE_W * NBYTE,
  localparam int OFF_W  = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lat_mode,
  input  logic              ld_n,
  input  logic              rw,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [NBYTE-1:0]  bw_n,
  output logic [WORD_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              rdata_vld,
  output logic              proto_err,
  output logic              k_phase
);
  import ddrb_pkg::*;

  logic ph_q;
  logic main_edge;
  op_e  op;
  logic rd_go, wr_go;
  logic last_rd_q;
  logic [OFF_W-1:0] rd_off;
  logic          rd_due, wr_due;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [WORD_W-1:0] arr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ~ph_q;
  end

  assign main_edge = ~ph_q;
  assign k_phase   = ph_q;
  assign op        = decode_op(ld_n, rw, main_edge);
  assign rd_go     = (op == OP_READ);
  assign wr_go     = (op == OP_WRITE);
  assign rd_off    = lat_mode ? OFF_W'(2) : OFF_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_rd_q <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      if (main_edge) last_rd_q <= rd_go;
      proto_err <= wr_go && last_rd_q;
    end
  end

  // R8: the error pulse follows a main-clock rise, so it is seen in phase 1
  a_r8_err_on_half: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> ph_q);

  ddrb_beat_line #(.AW(AW), .SLOTS(SLOTS)) u_rd_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .ins      (rd_go),
    .ins_off  (rd_off),
    .base     (addr),
    .due      (rd_due),
    .due_addr (rd_addr)
  );

  ddrb_beat_line #(.AW(AW), .SLOTS(SLOTS)) u_wr_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .ins      (wr_go),
    .ins_off  (OFF_W'(1)),
    .base     (addr),
    .due      (wr_due),
    .due_addr (wr_addr)
  );

  // R2: write word 0 is always committed at a main-clock rise
  a_r2_write_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_due && !$past(wr_due)) |-> main_edge);

  ddrb_array #(.AW(AW), .BYTE_W(BYTE_W), .NBYTE(NBYTE)) u_array (
    .clk    (clk),
    .we     (wr_due),
    .waddr  (wr_addr),
    .wdata  (wdata),
    .wsel_n (bw_n),
    .raddr  (rd_addr),
    .rdata  (arr_q)
  );

  ddrb_out_stage #(.WORD_W(WORD_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat      (rd_due),
    .main_edge (main_edge),
    .din       (arr_q),
    .q         (rdata),
    .vld       (rdata_vld),
    .oe        (rdata_oe)
  );

endmodule

// File: tb/ddr_burst_sram_tb.sv
module ddr_burst_sram_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int W  = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lat_mode = 1'b0;
  logic ld_n = 1'b1;
  logic rw = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0] wdata = '0;
  logic [1:0] bw_n = 2'b11;
  logic [W-1:0] rdata;
  logic rdata_oe, rdata_vld, proto_err, k_phase;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string cur_req = "R10";

  // behavioural reference model
  logic [W-1:0] mm [1<<AW];
  logic [AW-1:0] rd_due [int];
  logic [AW-1:0] wr_due [int];
  int e = 0;
  bit m_ph = 0;
  bit last_rd = 0;
  logic [W-1:0] ex_q = '0;
  bit ex_v = 0, ex_oe = 0, ex_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_burst_sram #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .lat_mode(lat_mode), .ld_n(ld_n), .rw(rw),
    .addr(addr), .wdata(wdata), .bw_n(bw_n), .rdata(rdata),
    .rdata_oe(rdata_oe), .rdata_vld(rdata_vld), .proto_err(proto_err),
    .k_phase(k_phase)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h (edge %0d)", cur_req, what, act, exp, e);
    end
  endtask

  function automatic logic [W-1:0] pat(input int k, input int beat);
    return W'((k * 1237 + beat * 611 + 77) ^ (k << 9));
  endfunction

  task automatic tick(input logic l, input logic r, input logic [AW-1:0] a,
                      input logic [W-1:0] d, input logic [1:0] b);
    int lat;
    ld_n = l; rw = r; addr = a; wdata = d; bw_n = b;
    lat = int'(lat_mode);
    if (rd_due.exists(e)) begin
      ex_q = mm[rd_due[e]]; ex_v = 1; ex_oe = 1; rd_due.delete(e);
    end else begin
      ex_v = 0;
      if (!m_ph) ex_oe = 0;
    end
    if (wr_due.exists(e)) begin
      if (!b[0]) mm[wr_due[e]][8:0]  = d[8:0];
      if (!b[1]) mm[wr_due[e]][17:9] = d[17:9];
      wr_due.delete(e);
    end
    ex_err = 0;
    if (!m_ph) begin
      if (!l && r) begin
        rd_due[e+2+lat] = a;
        rd_due[e+3+lat] = a ^ AW'(1);
      end
      if (!l && !r) begin
        wr_due[e+2] = a;
        wr_due[e+3] = a ^ AW'(1);
        ex_err = last_rd;
      end
      last_rd = !l && r;
    end
    m_ph = !m_ph;
    e++;
    @(posedge clk);
    @(negedge clk);
    chk("rdata (R1)", 32'(rdata), 32'(ex_q));
    chk("rdata_vld (R4)", 32'(rdata_vld), 32'(ex_v));
    chk("rdata_oe (R7)", 32'(rdata_oe), 32'(ex_oe));
    chk("proto_err (R8)", 32'(proto_err), 32'(ex_err));
    chk("k_phase (R10)", 32'(k_phase), 32'(m_ph));
  endtask

  // one main cycle: command at the main rise, then the half-cycle edge
  task automatic cyc2(input logic l, input logic r, input logic [AW-1:0] a,
                      input logic [W-1:0] d0, input logic [1:0] b0,
                      input logic [W-1:0] d1, input logic [1:0] b1);
    tick(l, r, a, d0, b0);
    tick(1'b1, 1'b0, '0, d1, b1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc2(1'b1, 1'b0, '0, '0, 2'b11, '0, 2'b11);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1<<AW); i++) mm[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R10";
    chk("reset rdata", 32'(rdata), 0);
    chk("reset vld", 32'(rdata_vld), 0);
    chk("reset oe", 32'(rdata_oe), 0);
    chk("reset err", 32'(proto_err), 0);
    chk("reset phase", 32'(k_phase), 0);

    // R2 R6: back-to-back writes fill every location
    cur_req = "R2 R6";
    for (int k = 0; k <= 32; k++)
      cyc2((k < 32) ? 1'b0 : 1'b1, 1'b0, AW'(2*k),
           (k > 0) ? pat(k-1, 0) : '0, 2'b00,
           (k > 0) ? pat(k-1, 1) : '0, 2'b00);
    idle(2);

    // R1 R3 R4: back-to-back reads, odd starts wrap the burst counter
    cur_req = "R1 R3 R4";
    cyc2(1'b0, 1'b1, 6'd5,  '0, 2'b11, '0, 2'b11);
    cyc2(1'b0, 1'b1, 6'd10, '0, 2'b11, '0, 2'b11);
    cyc2(1'b0, 1'b1, 6'd63, '0, 2'b11, '0, 2'b11);
    cyc2(1'b0, 1'b1, 6'd0,  '0, 2'b11, '0, 2'b11);
    // R7: bus released at the first idle main rise
    cur_req = "R7";
    idle(3);

    // R5: partial byte writes per beat
    cur_req = "R5";
    cyc2(1'b0, 1'b0, 6'd20, '0, 2'b11, '0, 2'b11);
    cyc2(1'b1, 1'b0, '0, 18'h2A5A5, 2'b10, 18'h15A5A, 2'b01);
    cyc2(1'b0, 1'b1, 6'd20, '0, 2'b11, '0, 2'b11);
    cyc2(1'b0, 1'b0, 6'd27, '0, 2'b11, '0, 2'b11);
    cyc2(1'b1, 1'b0, '0, 18'h3FFFF, 2'b11, 18'h00000, 2'b00);
    cyc2(1'b0, 1'b1, 6'd27, '0, 2'b11, '0, 2'b11);
    idle(3);

    // R1 R6: read of an address written in the previous cycle
    cur_req = "R1 R6";
    cyc2(1'b0, 1'b0, 6'd30, '0, 2'b11, '0, 2'b11);
    cyc2(1'b0, 1'b1, 6'd30, 18'h12345, 2'b00, 18'h0BEEF, 2'b00);
    idle(3);

    // R4 R7: longer latency
    cur_req = "R4 R7";
    lat_mode = 1'b1;
    cyc2(1'b0, 1'b1, 6'd7,  '0, 2'b11, '0, 2'b11);
    cyc2(1'b0, 1'b1, 6'd12, '0, 2'b11, '0, 2'b11);
    idle(2);
    cyc2(1'b0, 1'b1, 6'd41, '0, 2'b11, '0, 2'b11);
    idle(3);

    // R8: write straight after read; write must still land
    cur_req = "R8";
    cyc2(1'b0, 1'b1, 6'd40, '0, 2'b11, '0, 2'b11);
    cyc2(1'b0, 1'b0, 6'd41, '0, 2'b11, '0, 2'b11);
    cyc2(1'b1, 1'b0, '0, 18'h0AAAA, 2'b00, 18'h15555, 2'b00);
    idle(2);
    cyc2(1'b0, 1'b1, 6'd40, '0, 2'b11, '0, 2'b11);
    idle(3);

    // R9: commands at half-cycle edges are ignored
    cur_req = "R9";
    lat_mode = 1'b0;
    tick(1'b1, 1'b0, '0, '0, 2'b11);
    tick(1'b0, 1'b0, 6'd50, 18'h3C3C3, 2'b00);
    tick(1'b1, 1'b0, '0, 18'h3C3C3, 2'b00);
    tick(1'b0, 1'b1, 6'd51, '0, 2'b11);
    tick(1'b1, 1'b0, '0, 18'h3C3C3, 2'b00);
    tick(1'b0, 1'b0, 6'd50, 18'h3C3C3, 2'b00);
    idle(2);
    cyc2(1'b0, 1'b1, 6'd50, '0, 2'b11, '0, 2'b11);
    idle(3);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule